// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block takes one divider request for a single PLL and carries it out as a fixed, safe sequence of control steps. A request holds a reference divider, a feedback multiplier and an output divider. The request is first range-checked. A request that fails the check is refused with an error pulse and changes nothing. A request that passes starts the sequence. The sequencer drops the PLL into slow (bypass) mode and asserts the PLL reset. It loads the divider fields, each stored as its value minus one, and loads a bandwidth-adjust field derived from the multiplier. It keeps reset asserted for a fixed hold time and then releases it. It waits for the lock input and only then returns the PLL to normal mode.

If lock does not arrive within a parameterised window, the sequencer ends with an error pulse and leaves the PLL in slow mode. The analog PLL is outside the block. The block drives the field values plus the mode and reset controls, and it reads back one lock bit.

The state machine has nine states:

- `S_IDLE` accepts a request. A valid request goes to `S_SLOW`; an invalid one stays in `S_IDLE`.
- `S_SLOW` goes to `S_RSTON`, which goes to `S_PROG`.
- `S_PROG` goes to `S_HOLD`. `S_HOLD` stays there until the hold timer expires, then goes to `S_RELEASE`.
- `S_RELEASE` goes to `S_LOCK`.
- `S_LOCK` goes to `S_NORMAL` when lock is seen. If the timeout expires without lock, it goes to `S_FAIL`.
- `S_NORMAL` and `S_FAIL` both return to `S_IDLE`.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the outputs are as follows: `pll_mode` is 2'b00 (slow), `pll_rst` is 0, all four field outputs are 0, `busy` is 0, `req_ready` is 1, and `done` and `err` are 0.
- R2: `req_ready` is 1 exactly when the sequencer is idle. A `req_valid` presented while `busy` is 1 is ignored, so the fields loaded by the running sequence stay as they are.
- R3: A request is valid only when all of these hold: NR is in 1..64; NO is in 1..16 and NO is 1 or even; NF is in 2..8192; and REF_KHZ·NF lies within [440000·NR, 2200000·NR] kHz. An invalid request gives a one-cycle `err` pulse in the cycle after the handshake. It leaves `busy` at 0 and leaves the mode and all fields unchanged.
- R4: After a valid request is accepted on clock edge k, the outputs change in this order: `pll_mode` becomes 2'b00 at edge k+1, `pll_rst` becomes 1 at edge k+2, and the fields load at edge k+3. The fields never change unless the mode is slow and reset is high.
- R5: The fields are loaded as follows: `fld_nr` = NR−1 (6 bits), `fld_no` = NO−1 (4 bits) and `fld_nf` = NF−1 (13 bits).
- R6: `fld_bw` (12 bits) is loaded with floor(NF/2)−1.
- R7: `pll_rst` stays high for exactly HOLD_CYC+2 cycles, where HOLD_CYC = (CLK_HZ/1e6)·HOLD_US (500 at the defaults).
- R8: Lock is sampled only after reset has fallen. If lock is first seen at the D-th edge after the falling edge of reset, then `pll_mode` becomes 2'b01 (normal) and `done` pulses for one cycle at edge D+1.
- R9: If lock is still absent at edge LOCK_TIMEOUT after reset falls, `err` pulses at edge LOCK_TIMEOUT+1 and `pll_mode` stays 2'b00.
- R10: Lock seen at exactly edge LOCK_TIMEOUT after reset falls counts as success, not as a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer can take a request |
| req_nr | input | 7 | Reference divider value |
| req_no | input | 5 | Output divider value |
| req_nf | input | 14 | Feedback multiplier value |
| pll_lock | input | 1 | Lock status from the PLL |
| pll_mode | output | 2 | 00 slow/bypass, 01 normal |
| pll_rst | output | 1 | PLL reset control |
| fld_nr | output | 6 | NR−1 |
| fld_no | output | 4 | NO−1 |
| fld_nf | output | 13 | NF−1 |
| fld_bw | output | 12 | Bandwidth adjust, NF/2−1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle reject or timeout pulse |

## Verification
Lock arrival and lock-timeout expiry can fall in the same cycle. In that cycle the lock wins. The bench provokes this by making its lock model rise exactly LOCK_TIMEOUT edges after reset falls, and one edge later. The first case must give `done` and normal mode at the predicted edge. The second must give `err` with the mode left slow. A request strobed in the middle of a running sequence is the other collision. The bench judges it by comparing the fields loaded afterwards with the first request's values.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SLOW,
        S_RSTON,
        S_PROG,
        S_HOLD,
        S_RELEASE,
        S_LOCK,
        S_NORMAL,
        S_FAIL
    } seq_state_e;

    localparam logic [1:0] MODE_SLOW   = 2'b00;
    localparam logic [1:0] MODE_NORMAL = 2'b01;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
    parameter int NR_W        = 6,
    parameter int NO_W        = 4,
    parameter int NF_W        = 13,
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000
) (
    input  logic [NR_W:0] nr,
    input  logic [NO_W:0] no,
    input  logic [NF_W:0] nf,
    output logic          ok
);
    localparam int PW = 48;
    localparam logic [NR_W:0] NR_MAX = {1'b1, {NR_W{1'b0}}};
    localparam logic [NO_W:0] NO_MAX = {1'b1, {NO_W{1'b0}}};
    localparam logic [NF_W:0] NF_MAX = {1'b1, {NF_W{1'b0}}};
    localparam logic [NF_W:0] NF_MIN = NF_W'(2);

    logic          nr_ok, no_ok, nf_ok, vco_ok;
    logic [PW-1:0] vco_scaled, lo_bound, hi_bound;

    always_comb begin
        nr_ok      = (nr != '0) && (nr <= NR_MAX);
        no_ok      = (no != '0) && (no <= NO_MAX) &&
                     ((no == (NO_W+1)'(1)) || !no[0]);
        nf_ok      = (nf >= NF_MIN) && (nf <= NF_MAX);
        vco_scaled = PW'(REF_KHZ) * PW'(nf);
        lo_bound   = PW'(VCO_MIN_KHZ) * PW'(nr);
        hi_bound   = PW'(VCO_MAX_KHZ) * PW'(nr);
        vco_ok     = (vco_scaled >= lo_bound) && (vco_scaled <= hi_bound);
        ok         = nr_ok && no_ok && nf_ok && vco_ok;
    end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R7: the window counter never runs past its terminal value
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int HOLD_US      = 10,
    parameter int REF_KHZ      = 24000,
    parameter int VCO_MIN_KHZ  = 440000,
    parameter int VCO_MAX_KHZ  = 2200000,
    parameter int LOCK_TIMEOUT = 100000,
    parameter int NR_W         = 6,
    parameter int NO_W         = 4,
    parameter int NF_W         = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [NR_W:0]   req_nr,
    input  logic [NO_W:0]   req_no,
    input  logic [NF_W:0]   req_nf,
    input  logic            pll_lock,
    output logic [1:0]      pll_mode,
    output logic            pll_rst,
    output logic [NR_W-1:0] fld_nr,
    output logic [NO_W-1:0] fld_no,
    output logic [NF_W-1:0] fld_nf,
    output logic [NF_W-2:0] fld_bw,
    output logic            busy,
    output logic            done,
    output logic            err
);
    localparam int BW_W     = NF_W - 1;
    localparam int HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;

    seq_state_e state_q, state_d;

    logic            req_ok;
    logic            hold_exp, lock_exp;
    logic [NR_W:0]   lat_nr;
    logic [NO_W:0]   lat_no;
    logic [NF_W:0]   lat_nf;
    logic [NR_W:0]   nr_m1;
    logic [NO_W:0]   no_m1;
    logic [NF_W:0]   nf_m1;
    logic [NF_W-1:0] bw_m1;

    pll_req_check #(
        .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W),
        .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ)
    ) u_check (
        .nr(req_nr), .no(req_no), .nf(req_nf), .ok(req_ok)
    );

    pll_seq_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == S_HOLD), .expire(hold_exp)
    );

    pll_seq_timer #(.LIMIT(LOCK_TIMEOUT)) u_lock_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == S_LOCK), .expire(lock_exp)
    );

    assign req_ready = (state_q == S_IDLE);
    assign busy      = (state_q != S_IDLE);

    assign nr_m1 = lat_nr - (NR_W+1)'(1);
    assign no_m1 = lat_no - (NO_W+1)'(1);
    assign nf_m1 = lat_nf - (NF_W+1)'(1);
    assign bw_m1 = lat_nf[NF_W:1] - NF_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid && req_ok) state_d = S_SLOW;
            S_SLOW:    state_d = S_RSTON;
            S_RSTON:   state_d = S_PROG;
            S_PROG:    state_d = S_HOLD;
            S_HOLD:    if (hold_exp) state_d = S_RELEASE;
            S_RELEASE: state_d = S_LOCK;
            S_LOCK: begin
                if (pll_lock)      state_d = S_NORMAL;
                else if (lock_exp) state_d = S_FAIL;
            end
            S_NORMAL:  state_d = S_IDLE;
            S_FAIL:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_mode <= MODE_SLOW;
            pll_rst  <= 1'b0;
            fld_nr   <= '0;
            fld_no   <= '0;
            fld_nf   <= '0;
            fld_bw   <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            lat_nr   <= '0;
            lat_no   <= '0;
            lat_nf   <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid && req_ok) begin
                        lat_nr <= req_nr;
                        lat_no <= req_no;
                        lat_nf <= req_nf;
                    end
                    err <= req_valid && !req_ok;
                end
                S_SLOW:    pll_mode <= MODE_SLOW;
                S_RSTON:   pll_rst  <= 1'b1;
                S_PROG: begin
                    fld_nr <= nr_m1[NR_W-1:0];
                    fld_no <= no_m1[NO_W-1:0];
                    fld_nf <= nf_m1[NF_W-1:0];
                    fld_bw <= bw_m1[BW_W-1:0];
                end
                S_RELEASE: pll_rst <= 1'b0;
                S_NORMAL: begin
                    pll_mode <= MODE_NORMAL;
                    done     <= 1'b1;
                end
                S_FAIL:    err <= 1'b1;
                default: ;
            endcase
        end
    end

    // R4: divider fields move only while bypassed and held in reset
    p_fields_in_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({fld_nr, fld_no, fld_nf, fld_bw}) |-> (pll_mode == MODE_SLOW && pll_rst));

    // R8: normal mode is entered only after lock was sampled
    p_normal_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NORMAL) |-> $past(pll_lock));

    // R8: lock is watched only with reset released
    p_lock_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOCK) |-> !pll_rst);

    // R3: a refused request reports an error and starts nothing
    p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_ok) |=> (state_q == S_IDLE && err));

    // R9: a timeout leaves the PLL bypassed
    p_fail_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAIL) |=> (err && pll_mode == MODE_SLOW));

    // R8: completion flags never coincide
    p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;

    localparam int T_LOCK = 200;
    localparam int HOLD   = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_nr = '0;
    logic [4:0]  req_no = '0;
    logic [13:0] req_nf = '0;
    logic        pll_lock = 1'b0;
    logic [1:0]  pll_mode;
    logic        pll_rst;
    logic [5:0]  fld_nr;
    logic [3:0]  fld_no;
    logic [12:0] fld_nf;
    logic [11:0] fld_bw;
    logic        busy, done, err;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  lock_dly = 1;
    bit  lock_never = 1'b0;

    pll_reprog_seq #(.LOCK_TIMEOUT(T_LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_nr(req_nr), .req_no(req_no), .req_nf(req_nf), .pll_lock(pll_lock),
        .pll_mode(pll_mode), .pll_rst(pll_rst), .fld_nr(fld_nr), .fld_no(fld_no),
        .fld_nf(fld_nf), .fld_bw(fld_bw), .busy(busy), .done(done), .err(err)
    );

    always #10 clk = ~clk;

    // PLL lock model: lock rises lock_dly edges after reset falls
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            if (pll_rst) begin
                c = 0;
                pll_lock = 1'b0;
            end else begin
                c++;
                pll_lock = !lock_never && (c >= lock_dly);
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ok(int nr, int no, int nf);
        longint vco;
        vco = longint'(24000) * nf;
        if (nr < 1 || nr > 64) return 0;
        if (no < 1 || no > 16 || (no != 1 && no % 2 != 0)) return 0;
        if (nf < 2 || nf > 8192) return 0;
        return (vco >= longint'(440000) * nr) && (vco <= longint'(2200000) * nr);
    endfunction

    task automatic run_req(int nr, int no, int nf, int dly, bit never, bit poke);
        logic [5:0]  s_nr;
        logic [3:0]  s_no;
        logic [12:0] s_nf;
        logic [11:0] s_bw;
        logic [1:0]  s_mode;
        bit ok, fin, succ;
        int t, rst_hi, t_fall, t_done, t_err;
        logic [12:0] p_nf;
        logic [5:0]  p_nr;
        bit order_bad;
        @(negedge clk);
        s_nr = fld_nr; s_no = fld_no; s_nf = fld_nf; s_bw = fld_bw; s_mode = pll_mode;
        lock_dly = dly; lock_never = never;
        ok = exp_ok(nr, no, nf);
        chk("R2", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_nr = 7'(nr); req_no = 5'(no); req_nf = 14'(nf);
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            chk("R3", "reject err", err, 1);
            chk("R3", "reject busy", busy, 0);
            chk("R3", "reject fields", {fld_nr, fld_no, fld_nf, fld_bw}, {s_nr, s_no, s_nf, s_bw});
            chk("R3", "reject mode", pll_mode, s_mode);
            @(negedge clk);
            chk("R3", "err pulse width", err, 0);
            chk("R3", "reject mode later", pll_mode, s_mode);
            return;
        end
        chk("R2", "busy after accept", busy, 1);
        chk("R2", "ready low while busy", req_ready, 0);
        succ = !never && dly <= T_LOCK;
        t = 0; rst_hi = 0; t_fall = -1; t_done = -1; t_err = -1; fin = 0; order_bad = 0;
        p_nf = fld_nf; p_nr = fld_nr;
        while (!fin && t < HOLD + T_LOCK + 20) begin
            @(negedge clk);
            t++;
            if ((fld_nf != p_nf || fld_nr != p_nr) && !(pll_mode == 2'b00 && pll_rst)) order_bad = 1;
            p_nf = fld_nf; p_nr = fld_nr;
            if (t == 1) chk("R4", "mode slow at k+1", pll_mode, 0);
            if (t == 1) chk("R4", "reset low at k+1", pll_rst, 0);
            if (t == 2) chk("R4", "reset high at k+2", pll_rst, 1);
            if (t == 3) begin
                chk("R5", "nr field", fld_nr, nr - 1);
                chk("R5", "no field", fld_no, no - 1);
                chk("R5", "nf field", fld_nf, nf - 1);
                chk("R6", "bw field", fld_bw, nf / 2 - 1);
            end
            if (poke && t == 10) begin
                chk("R2", "ready low mid-sequence", req_ready, 0);
                req_valid = 1'b1; req_nr = 7'd2; req_no = 5'd2; req_nf = 14'd100;
            end
            if (poke && t == 12) req_valid = 1'b0;
            if (pll_rst) rst_hi++;
            if (t > 2 && !pll_rst && t_fall < 0) t_fall = t;
            if (done && t_done < 0) t_done = t;
            if (err && t_err < 0) t_err = t;
            fin = (t_done >= 0) || (t_err >= 0);
        end
        chk("R4", "fields only in slow+reset", order_bad, 0);
        chk("R7", "reset high cycles", rst_hi, HOLD + 2);
        chk("R7", "reset fall time", t_fall, HOLD + 4);
        if (poke) chk("R2", "busy request ignored", fld_nf, nf - 1);
        if (succ) begin
            chk(dly == T_LOCK ? "R10" : "R8", "done time", t_done, HOLD + 5 + dly);
            chk("R8", "mode normal", pll_mode, 1);
        end else begin
            chk("R9", "timeout err time", t_err, HOLD + 5 + T_LOCK);
            chk("R9", "mode stays slow", pll_mode, 0);
            chk("R9", "no done", t_done, -1);
        end
        @(negedge clk);
        chk("R8", "pulse cleared", {done, err}, 0);
        chk("R2", "idle after finish", busy, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        chk("R1", "mode", pll_mode, 0);
        chk("R1", "rst", pll_rst, 0);
        chk("R1", "fields", {fld_nr, fld_no, fld_nf, fld_bw}, 0);
        chk("R1", "busy/ready", {busy, req_ready}, 1);
        chk("R1", "done/err", {done, err}, 0);
        rst_n = 1'b1;
        // directed corners
        run_req(1, 1, 75, 5, 0, 0);          // 1800 MHz
        run_req(1, 3, 75, 5, 0, 0);          // odd NO: R3 reject, mode stays normal
        run_req(1, 0, 75, 5, 0, 0);          // NO zero
        run_req(1, 1, 18, 5, 0, 0);          // 432 MHz, too low
        run_req(12, 1, 1101, 5, 0, 0);       // just above 2200 MHz
        run_req(65, 2, 100, 5, 0, 0);        // NR out of range
        run_req(12, 1, 1100, 7, 0, 0);       // exactly 2200 MHz accepted
        run_req(1, 2, 19, 3, 0, 0);          // 456 MHz accepted
        run_req(64, 16, 5866, 4, 0, 0);      // field extremes
        run_req(2, 2, 100, T_LOCK, 0, 0);    // R10 lock on last window cycle
        run_req(2, 2, 100, T_LOCK + 1, 0, 0);// R9 one cycle late
        run_req(3, 4, 150, 1, 1, 0);         // never locks
        run_req(1, 2, 50, 9, 0, 1);          // R2 request poked while busy
        // constrained random
        for (int i = 0; i < 40; i++) begin
            int nr, no, nf, dly;
            bit nv;
            nr  = 1 + int'($urandom % 6);
            no  = int'($urandom % 18);
            nf  = 10 + int'($urandom % (100 * nr));
            dly = 1 + int'($urandom % T_LOCK);
            nv  = ($urandom % 8) == 0;
            run_req(nr, no, nf, dly, nv, 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule